// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Serializer

The serializer accepts one 28-bit pixel word per pixel period and spreads it across four single-bit data lanes, seven bits per lane per period, in a fixed bit assignment that is not in index order. A fifth lane forwards a clock pattern at the pixel rate. The pattern is high for the first four bit slots of every period and low for the last three. The receiving side uses this pattern to find the frame boundary.

All logic runs on a bit clock at seven times the pixel rate. The pixel clock arrives as a level input that is phase-aligned to the bit clock and is sampled on every bit-clock edge. A rising pixel-clock edge starts a new period at slot 0. A select input chooses whether the rising or the falling pixel-clock edge captures the input word. A word captured in one period is sent during the next period.

An active-low shutdown input clears all state and holds every output low. After shutdown or reset is released, a counter of pixel periods stands in for the phase-lock delay. The data lanes stay at zero until that counter expires and the valid output rises.

Top module: `ser7_tx`

## Requirements
- R1: With `edge_sel`=1 the word on `pix_data` is captured at the bit-clock edge that sees the rising edge of `pix_clk`. With `edge_sel`=0 it is captured at the edge that sees the falling edge of `pix_clk`.
- R2: `lane_data[0]` emits, from slot 0 to slot 6, captured bits 7, 6, 4, 3, 2, 1, 0.
- R3: `lane_data[1]` emits, from slot 0 to slot 6, captured bits 18, 15, 14, 13, 12, 9, 8.
- R4: `lane_data[2]` emits, from slot 0 to slot 6, captured bits 26, 25, 24, 22, 21, 20, 19.
- R5: `lane_data[3]` emits, from slot 0 to slot 6, captured bits 23, 17, 16, 11, 10, 5, 27.
- R6: `lane_clk` is 1 in slots 0 to 3 and 0 in slots 4 to 6 of each period. When `shdn_n` is high, every high phase of `lane_clk` lasts at least four bit clocks.
- R7: A rising `pix_clk` edge starts slot 0. Slot 0 appears on the outputs one bit clock after the bit-clock edge that sees the rise. The shifters reload at that point, so a word captured in one period is sent in the next period.
- R8: While `shdn_n` is 0, all registers are cleared and, from the next bit-clock edge on, `lane_data`, `lane_clk` and `link_valid` are 0.
- R9: After reset or shutdown is released, `link_valid` rises only after LOCK_PERIODS pixel periods (default 16) and then stays high until the next shutdown. While `link_valid` is 0, `lane_data` is 0.
- R10: Synchronous reset (`rst_n`=0) leaves `lane_data`, `lane_clk` and `link_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown and clear |
| edge_sel | input | 1 | 1: capture on the rising pixel edge, 0: capture on the falling pixel edge |
| pix_clk | input | 1 | Pixel clock, phase-aligned to `clk_bit` |
| pix_data | input | 28 | Parallel pixel word |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock lane (4 high, 3 low) |
| link_valid | output | 1 | Lock reached; data lanes carry data |

## Verification
The table pairs each word held until mid-period with a different word presented before the falling edge, so a wrong capture edge shows up as the wrong bits on every lane. Walking single bits (bit 7 alone, bit 27 alone, bits 5 and 23) confirm the slot order on individual lanes. Alternating patterns, a counting pattern and all-ones/all-zeros words detect swapped or shifted positions between lanes. Directed tests feed all-ones data before lock and during shutdown, which confirms that the lanes stay quiet and that the lock delay restarts.

// File: rtl/ser7_pkg.sv
// Shared constants and the lane bit-assignment function for the 7:1 serializer.
// Assumes four lanes of seven slots covering a 28-bit word.
package ser7_pkg;
    localparam int LANES = 4;
    localparam int SLOTS = 7;
    localparam int WORD_W = LANES * SLOTS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CLK_HIGH_SLOTS = 4;

    // Returns the pixel-word bit index sent on a lane in a given slot (slot 0 first).
    function automatic int src_bit(input int lane, input int slot);
        int r;
        r = 0;
        case (lane * SLOTS + slot)
            0: r = 7;   1: r = 6;   2: r = 4;   3: r = 3;
            4: r = 2;   5: r = 1;   6: r = 0;
            7: r = 18;  8: r = 15;  9: r = 14;  10: r = 13;
            11: r = 12; 12: r = 9;  13: r = 8;
            14: r = 26; 15: r = 25; 16: r = 24; 17: r = 22;
            18: r = 21; 19: r = 20; 20: r = 19;
            21: r = 23; 22: r = 17; 23: r = 16; 24: r = 11;
            25: r = 10; 26: r = 5;  27: r = 27;
            default: r = 0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ser7_slot_timer.sv
// Slot timer: samples the pixel clock on the bit clock, detects its edges,
// tracks the slot index and produces the forwarded clock lane.
// Assumes pix_clk changes away from the rising edge of clk.
module ser7_slot_timer
    import ser7_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic pix_clk,
    input  logic edge_sel,
    output logic capture,
    output logic period_start,
    output logic ck_lane
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] HIGH_END  = SLOT_W'(CLK_HIGH_SLOTS);

    logic              pclk_q;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic              rise;
    logic              fall;

    // Edge detection and choice of the next slot.
    always_comb begin
        rise         = pix_clk & ~pclk_q;
        fall         = ~pix_clk & pclk_q;
        period_start = rise | (slot_q == LAST_SLOT);
        slot_nxt     = period_start ? '0 : slot_q + 1'b1;
        capture      = edge_sel ? rise : fall;
    end

    // Slot counter, pixel-clock history and clock-lane register.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            pclk_q  <= 1'b0;
            slot_q  <= '0;
            ck_lane <= 1'b0;
        end else begin
            pclk_q  <= pix_clk;
            slot_q  <= slot_nxt;
            ck_lane <= (slot_nxt < HIGH_END);
        end
    end
endmodule

// File: rtl/ser7_lane_shift.sv
// One data lane: loads seven bits of the captured word in lane order at the
// period start, then shifts them out MSB first, one per bit clock.
module ser7_lane_shift
    import ser7_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              bit_out
);
    logic [SLOTS-1:0] sh_q;
    logic [SLOTS-1:0] load_val;

    for (genvar s = 0; s < SLOTS; s++) begin : g_pick
        assign load_val[SLOTS-1-s] = word[src_bit(LANE, s)];
    end

    // Reload at period start, otherwise shift toward the MSB.
    always_ff @(posedge clk) begin
        if (!clr_n)    sh_q <= '0;
        else if (load) sh_q <= load_val;
        else           sh_q <= {sh_q[SLOTS-2:0], 1'b0};
    end

    assign bit_out = sh_q[SLOTS-1];
endmodule

// File: rtl/ser7_lock_timer.sv
// Lock-delay model: counts pixel periods after the clear is released and
// asserts locked once LOCK_PERIODS periods have passed.
module ser7_lock_timer #(
    parameter int LOCK_PERIODS = 16
) (
    input  logic clk,
    input  logic clr_n,
    input  logic tick,
    output logic locked
);
    localparam int CW = $clog2(LOCK_PERIODS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_PERIODS);

    logic [CW-1:0] cnt_q;

    // Count period ticks until the limit, then hold.
    always_ff @(posedge clk) begin
        if (!clr_n)                     cnt_q <= '0;
        else if (tick && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign locked = (cnt_q == LIMIT);
endmodule

// File: rtl/ser7_tx.sv
// Four-lane 7:1 serializer top. Captures the pixel word on the selected
// pixel-clock edge and sends it on four lanes during the following period.
// Shutdown acts as a synchronous clear. Assumes clk_bit runs at seven times
// the pixel rate and is phase-aligned to pix_clk.
module ser7_tx
    import ser7_pkg::*;
#(
    parameter int LOCK_PERIODS = 16
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic              shdn_n,
    input  logic              edge_sel,
    input  logic              pix_clk,
    input  logic [WORD_W-1:0] pix_data,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk,
    output logic              link_valid
);
    logic              clr_n;
    logic              capture;
    logic              period_start;
    logic [WORD_W-1:0] word_q;
    logic [LANES-1:0]  raw;

    assign clr_n = rst_n & shdn_n;

    ser7_slot_timer u_timer (
        .clk          (clk_bit),
        .clr_n        (clr_n),
        .pix_clk      (pix_clk),
        .edge_sel     (edge_sel),
        .capture      (capture),
        .period_start (period_start),
        .ck_lane      (lane_clk)
    );

    // Capture register for the pixel word.
    always_ff @(posedge clk_bit) begin
        if (!clr_n)       word_q <= '0;
        else if (capture) word_q <= pix_data;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ser7_lane_shift #(.LANE(l)) u_lane (
            .clk     (clk_bit),
            .clr_n   (clr_n),
            .load    (period_start),
            .word    (word_q),
            .bit_out (raw[l])
        );
    end

    ser7_lock_timer #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
        .clk    (clk_bit),
        .clr_n  (clr_n),
        .tick   (period_start),
        .locked (link_valid)
    );

    assign lane_data = link_valid ? raw : '0;
endmodule

// File: rtl/ser7_tx_chk.sv
// Checker for the serializer outputs, bound to ser7_tx.
module ser7_tx_chk (
    input logic       clk_bit,
    input logic       rst_n,
    input logic       shdn_n,
    input logic [3:0] lane_data,
    input logic       lane_clk,
    input logic       link_valid
);
    AST_SHDN_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !shdn_n |=> (lane_data == 4'b0 && !lane_clk && !link_valid)); // R8

    AST_LANES_GATED: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !link_valid |-> lane_data == 4'b0); // R9

    AST_VALID_HOLDS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (link_valid && shdn_n) |=> link_valid); // R9

    AST_CLK_HIGH_SPAN: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($fell(lane_clk) && $past(shdn_n)) |-> ($past(lane_clk, 2) && $past(lane_clk, 3) && $past(lane_clk, 4))); // R6
endmodule

bind ser7_tx ser7_tx_chk u_chk (.*);

// File: tb/ser7_tx_test.sv
module ser7_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shdn_n = 1'b1;
    logic        edge_sel = 1'b1;
    logic        pix_clk = 1'b0;
    logic [27:0] pix_data = '0;
    logic [3:0]  lane_data;
    logic        lane_clk;
    logic        link_valid;

    int checks = 0;
    int errors = 0;
    int bph = 6;

    localparam int MAPB [4][7] = '{
        '{7, 6, 4, 3, 2, 1, 0},
        '{18, 15, 14, 13, 12, 9, 8},
        '{26, 25, 24, 22, 21, 20, 19},
        '{23, 17, 16, 11, 10, 5, 27}
    };
    localparam string LTAG [4] = '{"R2", "R3", "R4", "R5"};

    // {edge_sel, word present from the rise, word present from slot 2}
    localparam logic [56:0] VEC [7] = '{
        {1'b1, 28'h0000080, 28'h7FFFFFF},
        {1'b0, 28'h0000000, 28'h8000000},
        {1'b1, 28'h5555555, 28'hAAAAAAA},
        {1'b0, 28'h1234567, 28'hFEDCBA9},
        {1'b1, 28'hFFFFFFF, 28'h0000000},
        {1'b0, 28'hFFFFFFF, 28'h0800020},
        {1'b1, 28'h0800020, 28'hFFFFFFF}
    };

    ser7_tx uut (
        .clk_bit    (clk_bit_w),
        .rst_n      (rst_n),
        .shdn_n     (shdn_n),
        .edge_sel   (edge_sel),
        .pix_clk    (pix_clk),
        .pix_data   (pix_data),
        .lane_data  (lane_data),
        .lane_clk   (lane_clk),
        .link_valid (link_valid)
    );
    wire clk_bit_w = clk;

    always #2 clk = ~clk;

    // Pixel clock: 4 bit clocks high, 3 low, changed on the falling bit edge.
    always @(negedge clk) begin
        bph     <= (bph + 1) % 7;
        pix_clk <= ((bph + 1) % 7) < 4;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_ph(input int p);
        do begin
            @(negedge clk);
            #1;
        end while (bph != p);
    endtask

    task automatic wait_periods(input int n);
        for (int i = 0; i < n; i++) wait_ph(0);
    endtask

    // Run one vector: captured word is checked slot by slot in the next period.
    task automatic run_vec(input logic sel, input logic [27:0] wa, input logic [27:0] wb);
        logic [27:0] exp_w;
        exp_w = sel ? wa : wb;
        wait_ph(0);
        edge_sel = sel;
        pix_data = wa;
        wait_ph(2);
        pix_data = wb;
        wait_ph(0);
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            #1;
            for (int l = 0; l < 4; l++)
                chk({LTAG[l], " R1 R7"}, 32'(lane_data[l]), 32'(exp_w[MAPB[l][s]]));
            chk("R6", 32'(lane_clk), 32'(s < 4));
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pix_data = 28'hFFFFFFF;
        repeat (10) @(negedge clk);
        #1;
        chk("R10 lanes", 32'(lane_data), 0);
        chk("R10 clk", 32'(lane_clk), 0);
        chk("R10 valid", 32'(link_valid), 0);
        rst_n = 1'b1;
        wait_periods(3);
        for (int s = 0; s < 7; s++) begin
            @(negedge clk);
            #1;
            chk("R9 lanes before lock", 32'(lane_data), 0);
        end
        chk("R9 valid early", 32'(link_valid), 0);
        wait_periods(20);
        chk("R9 valid after lock", 32'(link_valid), 1);

        foreach (VEC[i]) run_vec(VEC[i][56], VEC[i][55:28], VEC[i][27:0]);

        // Shutdown: outputs quiet, lock restarts.
        pix_data = 28'hFFFFFFF;
        wait_ph(1);
        shdn_n = 1'b0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            #1;
            chk("R8 lanes", 32'(lane_data), 0);
            chk("R8 clk", 32'(lane_clk), 0);
            chk("R8 valid", 32'(link_valid), 0);
        end
        shdn_n = 1'b1;
        wait_periods(8);
        chk("R9 valid after shutdown early", 32'(link_valid), 0);
        chk("R9 lanes after shutdown early", 32'(lane_data), 0);
        wait_periods(14);
        chk("R9 valid relock", 32'(link_valid), 1);
        run_vec(1'b0, 28'h0000000, 28'h0F0F0F1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule